// File: doc/BRIEF.md
# Input Voltage Feed-Forward Term Generator

The block produces the duty-cycle feed-forward contribution that a digital power loop adds to its PID output to obtain the PWM duty target. On an accepted start request it captures a 12-bit voltage reference, a source select, the candidate input-voltage values and the scale factors. It scales the reference into the true output-voltage target and multiplies that target by the reciprocal of the selected input voltage. The result is an unsigned fraction with 10 fractional bits.

Four sources are selectable. Two are rectified-voltage measurements, whose reciprocal is produced by a restoring sequential divider and then scaled. The other two are a reciprocal already supplied by a primary-side sensor and a programmable override reciprocal. In peak-current-mode the control loop already rejects input disturbances, so the term is forced to zero. Each result is presented with a one-cycle completion pulse, and the output register holds its value between results.

Top module: `vff_term_gen`

## Requirements
- R1: After reset `ff_o` is 0 and `done_o` is 0.
- R2: When `pcm_mode_i` was 1 at the accepted start, the delivered `ff_o` is 0 whatever the other inputs are.
- R3: `src_sel_i` selects the reciprocal source: 0 = reciprocal of `vrect_a_i`, 1 = reciprocal of `vrect_b_i`, 2 = `inv_vin_i`, 3 = `ovr_recip_i`. Reciprocals are unsigned with 20 fractional bits and are 16 bits wide.
- R4: The target is t = floor(`vref_i` * `vout_scale_i` / 2^12), where `vout_scale_i` is U0.12. The delivered term is min(floor(t * recip / 2^10), 1023).
- R5: For sources 0 and 1 the reciprocal is min(floor(2^20 / v), 65535). It is then scaled to min(floor(recip * `rect_scale_i` / 2^11), 65535), where `rect_scale_i` is U1.11.
- R6: A rectified input of 0 yields the maximum reciprocal, 65535, before scaling.
- R7: A product above the U0.10 range saturates `ff_o` to 1023.
- R8: `done_o` is a one-cycle pulse. It rises 1 cycle after the accepting clock edge for sources 2 and 3, and 23 cycles after it for sources 0 and 1. `ff_o` changes only together with `done_o`.
- R9: `start_i` is accepted only while the block is idle. A start that arrives while busy is ignored. Changes to the select or to any data input after the accepting edge do not affect the result in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new computation |
| pcm_mode_i | input | 1 | 1 = peak-current mode (term forced to 0) |
| src_sel_i | input | 2 | Input-voltage source select |
| vref_i | input | 12 | Voltage reference, U12.0 |
| vout_scale_i | input | 12 | Reference-to-output scale, U0.12 |
| vrect_a_i | input | 12 | Rectified voltage measurement A, U12.0 |
| vrect_b_i | input | 12 | Rectified voltage measurement B, U12.0 |
| rect_scale_i | input | 12 | Rectified-reciprocal scale, U1.11 |
| inv_vin_i | input | 16 | Primary-side input-voltage reciprocal |
| ovr_recip_i | input | 16 | Override reciprocal |
| done_o | output | 1 | Result-complete pulse |
| ff_o | output | 10 | Feed-forward term, U0.10 |

## Verification
Two functions can fall in the same cycle. One is the completion pulse of one computation. The other is a start request, which is accepted there because the block has just returned to idle. The bench raises `start_i` in the exact cycle where `done_o` is visible, and also one cycle earlier, while the block is still busy. The behavioural model judges both on every clock: the earlier request must be dropped, the later one must produce a second result at the right latency, and the first result must stay undisturbed on `ff_o` until then.

// File: rtl/vff_pkg.sv
package vff_pkg;
  typedef enum logic [1:0] {
    SRC_RECT_A = 2'd0,
    SRC_RECT_B = 2'd1,
    SRC_PRI    = 2'd2,
    SRC_OVR    = 2'd3
  } vff_src_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_MUL  = 2'd2
  } vff_st_e;
endpackage

// File: rtl/vff_sat_mul.sv
// Unsigned product, right shift, saturate to O_W bits.
module vff_sat_mul #(
  parameter int A_W = 12,
  parameter int B_W = 12,
  parameter int SH  = 12,
  parameter int O_W = 12
) (
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic [O_W-1:0] p_o
);
  localparam int P_W = A_W + B_W;

  logic [P_W-1:0] prod;
  logic [P_W-1:0] prod_sh;

  always_comb begin
    prod    = P_W'(a_i) * P_W'(b_i);
    prod_sh = prod >> SH;
    p_o     = (|prod_sh[P_W-1:O_W]) ? {O_W{1'b1}} : prod_sh[O_W-1:0];
  end
endmodule

// File: rtl/vff_recip_div.sv
// Restoring divider: quot_o = floor(2^NUM_SH / den_i), one bit per cycle.
module vff_recip_div #(
  parameter int D_W    = 12,
  parameter int NUM_SH = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [D_W-1:0]    den_i,
  output logic              done_o,
  output logic [NUM_SH:0]   quot_o
);
  localparam int N_W   = NUM_SH + 1;
  localparam int CNT_W = $clog2(N_W + 1);

  logic [N_W-1:0]   q_q;
  logic [D_W-1:0]   rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic [D_W:0]     trial;
  logic [D_W:0]     diff;

  always_comb begin
    trial = {rem_q, q_q[N_W-1]};
    diff  = trial - {1'b0, den_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q    <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      q_q    <= N_W'(1) << NUM_SH;
      rem_q  <= '0;
      cnt_q  <= CNT_W'(N_W);
      done_q <= 1'b0;
    end else if (cnt_q != '0) begin
      // divisor 0 always restores positive: quotient ends all ones
      if (trial >= {1'b0, den_i}) begin
        rem_q <= diff[D_W-1:0];
        q_q   <= {q_q[N_W-2:0], 1'b1};
      end else begin
        rem_q <= trial[D_W-1:0];
        q_q   <= {q_q[N_W-2:0], 1'b0};
      end
      cnt_q  <= cnt_q - 1'b1;
      done_q <= (cnt_q == CNT_W'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quot_o = q_q;
endmodule

// File: rtl/vff_term_gen.sv
module vff_term_gen
  import vff_pkg::*;
#(
  parameter int VREF_W   = 12,
  parameter int VS_W     = 12,
  parameter int VS_FRAC  = 12,
  parameter int VR_W     = 12,
  parameter int RS_W     = 12,
  parameter int RS_FRAC  = 11,
  parameter int RCP_W    = 16,
  parameter int RCP_FRAC = 20,
  parameter int FF_W     = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              pcm_mode_i,
  input  logic [1:0]        src_sel_i,
  input  logic [VREF_W-1:0] vref_i,
  input  logic [VS_W-1:0]   vout_scale_i,
  input  logic [VR_W-1:0]   vrect_a_i,
  input  logic [VR_W-1:0]   vrect_b_i,
  input  logic [RS_W-1:0]   rect_scale_i,
  input  logic [RCP_W-1:0]  inv_vin_i,
  input  logic [RCP_W-1:0]  ovr_recip_i,
  output logic              done_o,
  output logic [FF_W-1:0]   ff_o
);
  localparam int Q_W   = RCP_FRAC + 1;
  localparam int FF_SH = RCP_FRAC - FF_W;

  vff_st_e            st_q;
  logic               accept;
  logic               busy_q;
  logic               pcm_q;
  logic [1:0]         sel_q;
  logic [VREF_W-1:0]  vref_q;
  logic [VS_W-1:0]    vscale_q;
  logic [RS_W-1:0]    rscale_q;
  logic [VR_W-1:0]    den_q;
  logic [RCP_W-1:0]   recip_q;
  logic [FF_W-1:0]    ff_q;
  logic               done_q;

  logic               div_start;
  logic               div_done;
  logic [Q_W-1:0]     div_quot;
  logic [RCP_W-1:0]   raw_recip;
  logic [RCP_W-1:0]   rect_recip;
  logic [VREF_W-1:0]  vout_tgt;
  logic [FF_W-1:0]    ff_sat;

  assign accept    = (st_q == ST_IDLE) && start_i;
  assign busy_q    = (st_q != ST_IDLE);
  assign div_start = accept && !src_sel_i[1];
  assign raw_recip = (|div_quot[Q_W-1:RCP_W]) ? {RCP_W{1'b1}} : div_quot[RCP_W-1:0];

  vff_recip_div #(.D_W(VR_W), .NUM_SH(RCP_FRAC)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(div_start),
    .den_i  (den_q),
    .done_o (div_done),
    .quot_o (div_quot)
  );

  vff_sat_mul #(.A_W(RCP_W), .B_W(RS_W), .SH(RS_FRAC), .O_W(RCP_W)) u_rect_scl (
    .a_i(raw_recip), .b_i(rscale_q), .p_o(rect_recip)
  );

  vff_sat_mul #(.A_W(VREF_W), .B_W(VS_W), .SH(VS_FRAC), .O_W(VREF_W)) u_tgt (
    .a_i(vref_q), .b_i(vscale_q), .p_o(vout_tgt)
  );

  vff_sat_mul #(.A_W(VREF_W), .B_W(RCP_W), .SH(FF_SH), .O_W(FF_W)) u_ff (
    .a_i(vout_tgt), .b_i(recip_q), .p_o(ff_sat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      pcm_q    <= 1'b0;
      sel_q    <= '0;
      vref_q   <= '0;
      vscale_q <= '0;
      rscale_q <= '0;
      den_q    <= '0;
      recip_q  <= '0;
      ff_q     <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          pcm_q    <= pcm_mode_i;
          sel_q    <= src_sel_i;
          vref_q   <= vref_i;
          vscale_q <= vout_scale_i;
          rscale_q <= rect_scale_i;
          den_q    <= src_sel_i[0] ? vrect_b_i : vrect_a_i;
          if (src_sel_i[1]) begin
            recip_q <= (src_sel_i == SRC_OVR) ? ovr_recip_i : inv_vin_i;
            st_q    <= ST_MUL;
          end else begin
            st_q    <= ST_DIV;
          end
        end
        ST_DIV: if (div_done) begin
          recip_q <= rect_recip;
          st_q    <= ST_MUL;
        end
        ST_MUL: begin
          ff_q   <= pcm_q ? '0 : ff_sat;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign ff_o   = ff_q;
endmodule

// File: rtl/vff_chk.sv
module vff_chk #(
  parameter int VR_W = 12,
  parameter int Q_W  = 21,
  parameter int FF_W = 10
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            done_o,
  input logic [FF_W-1:0] ff_o,
  input logic            busy_i,
  input logic            pcm_i,
  input logic [1:0]      sel_i,
  input logic            div_done_i,
  input logic [VR_W-1:0] den_i,
  input logic [Q_W-1:0]  quot_i
);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  ff_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(ff_o));

  // R8
  idle_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_i);

  // R2
  pcm_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pcm_i) |-> (ff_o == '0));

  // R9
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && start_i) |=> $stable(sel_i));

  // R6
  div_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_done_i && den_i == '0) |-> (&quot_i));
endmodule

bind vff_term_gen vff_chk #(.VR_W(VR_W), .Q_W(Q_W), .FF_W(FF_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .done_o    (done_o),
  .ff_o      (ff_o),
  .busy_i    (busy_q),
  .pcm_i     (pcm_q),
  .sel_i     (sel_q),
  .div_done_i(div_done),
  .den_i     (den_q),
  .quot_i    (div_quot)
);

// File: tb/sim_vff_term_gen.sv
`timescale 1ns/1ps
module sim_vff_term_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        pcm = 1'b0;
  logic [1:0]  sel = '0;
  logic [11:0] vref = '0, vscale = '0, va = '0, vb = '0, rscale = '0;
  logic [15:0] ivin = '0, ovr = '0;
  logic        done;
  logic [9:0]  ff;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";

  // behavioural model state
  longint cyc = 0, due = -1, busy_until = 0;
  longint pending = 0, m_ff = 0;
  bit     m_done = 0;

  always #5 clk = ~clk;

  vff_term_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pcm_mode_i(pcm),
    .src_sel_i(sel), .vref_i(vref), .vout_scale_i(vscale),
    .vrect_a_i(va), .vrect_b_i(vb), .rect_scale_i(rscale),
    .inv_vin_i(ivin), .ovr_recip_i(ovr), .done_o(done), .ff_o(ff)
  );

  function automatic longint sat(longint v, longint mx);
    return (v > mx) ? mx : v;
  endfunction

  function automatic longint calc();
    longint t, r, v;
    t = (longint'(vref) * longint'(vscale)) >> 12;
    if (sel < 2) begin
      v = (sel == 0) ? longint'(va) : longint'(vb);
      r = (v == 0) ? 65535 : sat((longint'(1) << 20) / v, 65535);
      r = sat((r * longint'(rscale)) >> 11, 65535);
    end else begin
      r = (sel == 2) ? longint'(ivin) : longint'(ovr);
    end
    if (pcm) return 0;
    return sat((t * r) >> 10, 1023);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ff = 0; m_done = 0; due = -1; busy_until = 0; cyc = 0;
    end else begin
      cyc = cyc + 1;
      if (cyc == due) begin m_done = 1; m_ff = pending; end
      else m_done = 0;
      if (start && cyc > busy_until) begin
        pending = calc();
        due = cyc + ((sel < 2) ? 23 : 1);
        busy_until = due;
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (!rst_n) begin
      if (ff !== 10'd0 || done !== 1'b0) begin
        errors++;
        $display("FAIL R1: reset ff=%0d done=%0d expected ff=0 done=0", ff, done);
      end
    end else if (done !== m_done || longint'(ff) != m_ff) begin
      errors++;
      $display("FAIL %s/R8: cycle %0d ff=%0d done=%0d expected ff=%0d done=%0d",
               cur_req, cyc, ff, done, m_ff, m_done);
    end
  end

  task automatic setin(bit p, logic [1:0] s, logic [11:0] vr, logic [11:0] vs,
                       logic [11:0] a, logic [11:0] b, logic [11:0] rs,
                       logic [15:0] iv, logic [15:0] ov);
    pcm = p; sel = s; vref = vr; vscale = vs; va = a; vb = b; rscale = rs;
    ivin = iv; ovr = ov;
  endtask

  task automatic pulse();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);

    cur_req = "R3_override";
    setin(0, 2'd3, 12'd2048, 12'd4095, 12'd0, 12'd0, 12'd2048, 16'd0, 16'd349);
    pulse(); idle(4);

    cur_req = "R3_primary R4";
    setin(0, 2'd2, 12'd3000, 12'd2000, 12'd0, 12'd0, 12'd2048, 16'd500, 16'd7);
    pulse(); idle(4);

    cur_req = "R5_rect_a";
    setin(0, 2'd0, 12'd1800, 12'd4000, 12'd3000, 12'd5, 12'd2048, 16'd9, 16'd9);
    pulse(); idle(30);

    cur_req = "R5_rect_b";
    setin(0, 2'd1, 12'd1200, 12'd3500, 12'd7, 12'd2500, 12'd2900, 16'd9, 16'd9);
    pulse(); idle(30);

    cur_req = "R2_pcm";
    setin(1, 2'd0, 12'd4000, 12'd4095, 12'd3000, 12'd0, 12'd2048, 16'd0, 16'd0);
    pulse(); idle(30);
    setin(1, 2'd3, 12'd4000, 12'd4095, 12'd0, 12'd0, 12'd0, 16'd0, 16'd60000);
    pulse(); idle(4);

    cur_req = "R6_div_zero";
    setin(0, 2'd1, 12'd1, 12'd2048, 12'd100, 12'd0, 12'd2048, 16'd0, 16'd0);
    pulse(); idle(30);

    cur_req = "R7_saturate";
    setin(0, 2'd0, 12'd4000, 12'd4095, 12'd2, 12'd0, 12'd4095, 16'd0, 16'd0);
    pulse(); idle(30);
    setin(0, 2'd3, 12'd4095, 12'd4095, 12'd0, 12'd0, 12'd0, 16'd0, 16'd65535);
    pulse(); idle(4);

    // R9: inputs change right after acceptance, starts while busy
    cur_req = "R9_busy";
    setin(0, 2'd0, 12'd2500, 12'd3000, 12'd2000, 12'd900, 12'd2048, 16'd1, 16'd1);
    pulse();
    setin(0, 2'd3, 12'd100, 12'd10, 12'd1, 12'd1, 12'd4095, 16'd2, 16'd40000);
    idle(3); pulse(); idle(10); pulse(); idle(30);

    // R9/R8: start one cycle before done (ignored) and in the done cycle (accepted)
    cur_req = "R9_done_cycle";
    setin(0, 2'd2, 12'd3500, 12'd3000, 12'd0, 12'd0, 12'd0, 16'd300, 16'd0);
    @(negedge clk); start = 1'b1;
    @(negedge clk);
    setin(0, 2'd3, 12'd3000, 12'd3000, 12'd0, 12'd0, 12'd0, 16'd0, 16'd250);
    @(negedge clk);
    setin(0, 2'd0, 12'd2000, 12'd4000, 12'd1500, 12'd0, 12'd1024, 16'd0, 16'd0);
    @(negedge clk); start = 1'b0;
    idle(30);

    cur_req = "R8_back_to_back";
    for (int i = 0; i < 6; i++) begin
      setin(0, 2'(i % 4), 12'(300 + i * 611), 12'(1000 + i * 500),
            12'(50 + i * 700), 12'(4000 - i * 600), 12'(1500 + i * 200),
            16'(200 + i * 90), 16'(1000 + i * 333));
      pulse(); idle((i % 4) < 2 ? 24 : 1);
    end
    idle(30);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule